// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block watches the operands and the result of the most recent add, subtract or bitwise logic operation and turns them into six status flags: carry, parity, auxiliary carry, zero, sign and overflow. The flags sit at fixed bit positions inside a registered 32-bit flags word. The other bits of the word hold control settings such as trap, interrupt enable and direction. This block never changes them, so they keep the value given by the reset parameter.

The datapath drives the two operands and the result it produced, an operand-size select (8, 16 or 32 bits) and an operation class. It pulses the write enable on the cycle the flags should change. Carry and overflow come from the top bits of the operands and the result at the selected width. The auxiliary carry comes from bit 4, and serves decimal adjust sequences on packed BCD data. Parity always looks at the low byte of the result.

Top module: `flag_status_top`

## Requirements
- R1: A synchronous active-high reset loads the word with parameter RESET_VALUE (default 32'h0000_0202). The fixed status positions are: carry bit 0, parity bit 2, auxiliary carry bit 4, zero bit 6, sign bit 7, overflow bit 11.
- R2: The six status bits change only on a rising clock edge where the write enable is 1. When the write enable is 0, the whole word holds its value.
- R3: Bits of the word outside the six status positions never change after reset.
- R4: Sign takes bit 7, 15 or 31 of the result for size select 0, 1 or 2. Size select 3 behaves as 2.
- R5: Zero is 1 only when every result bit inside the selected width is 0. Result bits above that width are ignored, so zero and sign are never both 1 after a write.
- R6: Parity is 1 when result bits 7..0 hold an even number of ones and 0 when they hold an odd number. This holds for every size.
- R7: Auxiliary carry is 1 on a carry out of bit 3 for add (class 0), or a borrow into bit 3 for subtract (class 1). It is 0 otherwise. For logic (class 2 or 3) it keeps its previous value.
- R8: Carry is 1 on a carry out of the top bit of the selected width for add, or a borrow into it for subtract. It is 0 for logic.
- R9: Overflow is 1 when the add or subtract gave a signed two's-complement overflow at the selected width. It is 0 for logic.
- R10: Operand bits above the selected width have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Latch new status flags this cycle |
| size_i | input | 2 | Operand size: 0 byte, 1 half, 2 or 3 full word |
| op_i | input | 2 | Operation class: 0 add, 1 subtract, 2 or 3 logic |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| res_i | input | 32 | Result the datapath produced |
| flags_o | output | 32 | Registered flags word |

## Verification
The bench targets results that are zero at the selected width but carry garbage in the upper bits. A design that tests all 32 bits would then miss the zero flag. It also drives subtractions that borrow at bit 3 or at the top bit. A design that reuses the add carry equation would report no borrow there. Signed-boundary additions such as 0x7F+1 and 0x8000_0000+0x8000_0000 expose an overflow or carry taken from the wrong width. Logic operations that follow an add with a set auxiliary carry show whether that flag is wrongly cleared, and whether carry and overflow are wrongly kept.

// File: rtl/flag_pkg.sv
package flag_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SIZES = 3;

    localparam int FLAG_CF = 0;
    localparam int FLAG_PF = 2;
    localparam int FLAG_AF = 4;
    localparam int FLAG_ZF = 6;
    localparam int FLAG_SF = 7;
    localparam int FLAG_OF = 11;

    localparam logic [DATA_W-1:0] STATUS_MASK =
        (DATA_W'(1) << FLAG_CF) | (DATA_W'(1) << FLAG_PF) |
        (DATA_W'(1) << FLAG_AF) | (DATA_W'(1) << FLAG_ZF) |
        (DATA_W'(1) << FLAG_SF) | (DATA_W'(1) << FLAG_OF);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_FULL  = 2'd2,
        SZ_FULL2 = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        OPC_ADD    = 2'd0,
        OPC_SUB    = 2'd1,
        OPC_LOGIC  = 2'd2,
        OPC_LOGIC2 = 2'd3
    } op_class_e;

    // Top bits of the operands and result at the selected width.
    typedef struct packed {
        logic a_top;
        logic b_top;
        logic r_top;
    } top_bits_t;

    typedef struct packed {
        logic cf;
        logic af;
        logic of;
        logic af_upd;
    } arith_flags_t;

    typedef struct packed {
        logic zf;
        logic sf;
        logic pf;
    } result_flags_t;

    function automatic logic even_parity8(input logic [7:0] v);
        return ~(^v);
    endfunction

    function automatic int unsigned size_index(input op_size_e s);
        case (s)
            SZ_BYTE: return 0;
            SZ_HALF: return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/flag_size_view.sv
module flag_size_view
    import flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] res_i,
    input  op_size_e     size_i,
    output top_bits_t    top_o,
    output logic         zero_o
);
    logic [NUM_SIZES-1:0] zero_v;
    top_bits_t            top_v [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int SW = 8 << g;
        assign zero_v[g]       = ~|res_i[SW-1:0];
        assign top_v[g].a_top  = opa_i[SW-1];
        assign top_v[g].b_top  = opb_i[SW-1];
        assign top_v[g].r_top  = res_i[SW-1];
    end

    always_comb begin
        top_o  = top_v[size_index(size_i)];
        zero_o = zero_v[size_index(size_i)];
    end

endmodule

// File: rtl/flag_arith_eval.sv
module flag_arith_eval
    import flag_pkg::*;
(
    input  top_bits_t    top_i,
    input  logic         a4_i,
    input  logic         b4_i,
    input  logic         r4_i,
    input  op_class_e    op_i,
    output arith_flags_t flags_o
);
    logic carry_add, borrow_sub, ovf_add, ovf_sub, nib_cross;

    always_comb begin
        carry_add  = (top_i.a_top & top_i.b_top) |
                     ((top_i.a_top | top_i.b_top) & ~top_i.r_top);
        borrow_sub = (~top_i.a_top & top_i.b_top) |
                     (~(top_i.a_top ^ top_i.b_top) & top_i.r_top);
        ovf_add    = ~(top_i.a_top ^ top_i.b_top) & (top_i.a_top ^ top_i.r_top);
        ovf_sub    =  (top_i.a_top ^ top_i.b_top) & (top_i.a_top ^ top_i.r_top);
        // Carry or borrow across the bit 3/4 boundary, valid for both add and sub.
        nib_cross  = a4_i ^ b4_i ^ r4_i;

        flags_o = '0;
        case (op_i)
            OPC_ADD: begin
                flags_o.cf     = carry_add;
                flags_o.of     = ovf_add;
                flags_o.af     = nib_cross;
                flags_o.af_upd = 1'b1;
            end
            OPC_SUB: begin
                flags_o.cf     = borrow_sub;
                flags_o.of     = ovf_sub;
                flags_o.af     = nib_cross;
                flags_o.af_upd = 1'b1;
            end
            default: begin
                flags_o.cf     = 1'b0;
                flags_o.of     = 1'b0;
                flags_o.af     = 1'b0;
                flags_o.af_upd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flag_status_top.sv
module flag_status_top
    import flag_pkg::*;
#(
    parameter logic [31:0] RESET_VALUE = 32'h0000_0202
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we_i,
    input  logic [1:0]  size_i,
    input  logic [1:0]  op_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic [31:0] res_i,
    output logic [31:0] flags_o
);
    op_size_e      size_e;
    op_class_e     op_e;
    top_bits_t     top_bits;
    logic          zero_sel;
    arith_flags_t  arith;
    result_flags_t resf;
    logic [31:0]   flags_q, flags_d;

    assign size_e = op_size_e'(size_i);
    assign op_e   = op_class_e'(op_i);

    flag_size_view #(.W(DATA_W)) u_view (
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .res_i  (res_i),
        .size_i (size_e),
        .top_o  (top_bits),
        .zero_o (zero_sel)
    );

    flag_arith_eval u_arith (
        .top_i   (top_bits),
        .a4_i    (opa_i[4]),
        .b4_i    (opb_i[4]),
        .r4_i    (res_i[4]),
        .op_i    (op_e),
        .flags_o (arith)
    );

    always_comb begin
        resf.zf = zero_sel;
        resf.sf = top_bits.r_top;
        resf.pf = even_parity8(res_i[7:0]);

        flags_d          = flags_q;
        flags_d[FLAG_CF] = arith.cf;
        flags_d[FLAG_OF] = arith.of;
        flags_d[FLAG_ZF] = resf.zf;
        flags_d[FLAG_SF] = resf.sf;
        flags_d[FLAG_PF] = resf.pf;
        if (arith.af_upd)
            flags_d[FLAG_AF] = arith.af;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= RESET_VALUE;
        else if (we_i)
            flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(flags_o)) else $error("hold failed"); // R2

    AST_CTRL_BITS_FIXED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_o & ~STATUS_MASK) == ($past(flags_o) & ~STATUS_MASK)))
        else $error("control bits moved"); // R3

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
        we_i |=> !(flags_o[FLAG_ZF] && flags_o[FLAG_SF])) else $error("zf and sf"); // R5

    AST_LOGIC_AF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (we_i && op_i[1]) |=> (flags_o[FLAG_AF] == $past(flags_o[FLAG_AF])))
        else $error("af changed on logic"); // R7

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (we_i && op_i[1]) |=> !flags_o[FLAG_CF]) else $error("cf on logic"); // R8

    AST_LOGIC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (we_i && op_i[1]) |=> !flags_o[FLAG_OF]) else $error("of on logic"); // R9

endmodule

// File: tb/sim_flag_status_top.sv
module sim_flag_status_top;

    localparam logic [31:0] RST_WORD = 32'h0000_0202;
    localparam logic [31:0] ST_MASK  = 32'h0000_08D5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [1:0]  op_i = 2'd0;
    logic [31:0] opa_i = '0, opb_i = '0, res_i = '0;
    logic [31:0] flags_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model = RST_WORD;
    int unsigned seed_dummy;

    always #10 clk = ~clk;

    flag_status_top u0 (
        .clk(clk), .rst(rst), .we_i(we_i), .size_i(size_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i), .flags_o(flags_o)
    );

    function automatic int width_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] next_flags(input logic [31:0] prev,
        input logic [31:0] a, input logic [31:0] b, input logic [31:0] r,
        input logic [1:0] sz, input logic [1:0] op);
        int n = width_of(sz);
        longint unsigned full = 64'd1 << n;
        longint unsigned am = {32'd0, a} & (full - 1);
        longint unsigned bm = {32'd0, b} & (full - 1);
        longint unsigned rm = {32'd0, r} & (full - 1);
        longint sa = (am >= full / 2) ? longint'(am) - longint'(full) : longint'(am);
        longint sb = (bm >= full / 2) ? longint'(bm) - longint'(full) : longint'(bm);
        longint s;
        logic [31:0] f = prev;
        f[6] = (rm == 0);
        f[7] = r[n-1];
        f[2] = ~(^r[7:0]);
        if (op == 2'd0) begin
            f[0] = (am + bm) >= full;
            s = sa + sb;
            f[11] = (s >= longint'(full / 2)) || (s < -longint'(full / 2));
            f[4] = ((a & 32'hF) + (b & 32'hF)) > 32'hF;
        end else if (op == 2'd1) begin
            f[0] = am < bm;
            s = sa - sb;
            f[11] = (s >= longint'(full / 2)) || (s < -longint'(full / 2));
            f[4] = (a & 32'hF) < (b & 32'hF);
        end else begin
            f[0] = 1'b0;
            f[11] = 1'b0;
        end
        return f;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R8 carry",     flags_o[0],  model[0]);
        chk("R6 parity",    flags_o[2],  model[2]);
        chk("R7 auxcarry",  flags_o[4],  model[4]);
        chk("R5 zero",      flags_o[6],  model[6]);
        chk("R4 sign",      flags_o[7],  model[7]);
        chk("R9 overflow",  flags_o[11], model[11]);
        chk_word("R3 control bits", flags_o & ~ST_MASK, RST_WORD & ~ST_MASK);
    endtask

    // Drive at negedge, register at posedge, check at the following negedge.
    task automatic apply(input logic [1:0] sz, input logic [1:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] r, input logic we);
        @(negedge clk);
        size_i = sz; op_i = op; opa_i = a; opb_i = b; res_i = r; we_i = we;
        if (we) model = next_flags(model, a, b, r, sz, op);
        @(negedge clk);
        we_i = 1'b0;
        check_all();
    endtask

    task automatic rand_op(input logic we);
        logic [1:0] sz = 2'($urandom_range(0, 3));
        logic [1:0] op = 2'($urandom_range(0, 3));
        logic [31:0] a = $urandom;
        logic [31:0] b = $urandom;
        logic [31:0] r;
        logic [31:0] junk = $urandom;
        int n = width_of(sz);
        logic [31:0] mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
        if (($urandom % 8) == 0) b = a;
        case (op)
            2'd0: r = a + b;
            2'd1: r = a - b;
            default: case ($urandom % 3)
                0: r = a & b;
                1: r = a | b;
                default: r = a ^ b;
            endcase
        endcase
        r = r ^ (junk & ~mask);  // R10 upper bits ignored
        apply(sz, op, a, b, r, we);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_word("R1 reset word", flags_o, RST_WORD);

        // R8 R5 R7: byte add wrapping to zero with carry
        apply(2'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 32'hABCD_1200, 1'b1);
        // R9 R4: byte signed overflow 0x7F+1
        apply(2'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 32'h0000_0080, 1'b1);
        // R7: logic keeps auxiliary carry, clears carry and overflow
        apply(2'd0, 2'd2, 32'hFFFF_0000, 32'h0000_FFFF, 32'h0000_0000, 1'b1);
        // R9: half subtract 0x8000-1 overflow
        apply(2'd1, 2'd1, 32'h0000_8000, 32'h0000_0001, 32'h0000_7FFF, 1'b1);
        // R8: full subtract 0-1 borrow, sign set
        apply(2'd2, 2'd1, 32'h0, 32'h1, 32'hFFFF_FFFF, 1'b1);
        // R8 R9 R5: full add 0x8000_0000 twice, size 3 as full
        apply(2'd3, 2'd0, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b1);
        // R7: borrow into bit 3 on 0x10-1
        apply(2'd0, 2'd1, 32'h0000_0010, 32'h0000_0001, 32'h0000_000F, 1'b1);
        // R10: operand upper garbage does not affect byte flags
        apply(2'd0, 2'd0, 32'hF0F0_0001, 32'h0F0F_0001, 32'h1234_0002, 1'b1);
        // R6: parity of low byte only, 16-bit result
        apply(2'd1, 2'd2, 32'h0, 32'h0, 32'h0300_0103, 1'b1);
        // R2: no write leaves word unchanged
        apply(2'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 32'h0, 1'b0);

        for (int i = 0; i < 400; i++) rand_op(($urandom % 5) != 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule